// File: doc/BRIEF.md
# Gated I/Q Correlation Counter Bank

This block sits behind a digital downconverter in a code-and-carrier tracking receiver. Each cycle it may take one baseband sample, given as an in-phase sign and a quadrature sign. It correlates that sample against three replicas of the spreading code: one on time (prompt), one half a chip early and one half a chip late. For each replica it keeps an in-phase total and a quadrature total, which makes six signed up/down counters. The downconverter can mark a sample as blank (zero magnitude), and such a sample leaves every total where it was.

A one-cycle `dump` pulse marks the end of an integration interval. On that edge all six running totals are copied into a set of held registers, and the running counters restart. The tracking controller reads the held set through a small register port, computes the carrier phase by arctangent from the prompt pair, and uses the early/late difference to steer the code loop. A ready flag tells the controller when a fresh set is waiting.

Top module: `corr_bank`

## Requirements
- R1: After reset every running counter and every held register is zero, `data_ready` is 0 and `rd_valid` is 0.
- R2: A sample with `smp_valid`=1 and `smp_blank`=0 moves each counter by one step. Sign inputs and code bits use 0 for +1 and 1 for -1. The in-phase counter of a replica counts up when `sig_i` XOR the code bit is 0 and counts down when it is 1. The quadrature counter does the same with `sig_q`.
- R3: A cycle with `smp_blank`=1 or with `smp_valid`=0 changes no counter.
- R4: On a `dump` cycle the held registers take the totals accumulated up to, but not including, that cycle. A valid sample on the dump cycle is the first sample of the new interval, so no sample is lost.
- R5: Counters saturate at the signed limits of `CNT_W` bits, +(2^(CNT_W-1))-1 and -2^(CNT_W-1), and never wrap.
- R6: A read with `rd_en`=1 returns the addressed held value on `rd_data` with `rd_valid`=1 in the following cycle. The address map is: 0 prompt I, 1 prompt Q, 2 early I, 3 early Q, 4 late I, 5 late Q.
- R7: `data_ready` rises on the cycle after a dump. It clears after a read of address 5, and reads of other addresses leave it set. When a dump and a read of address 5 fall in the same cycle, the dump wins and the flag stays set.
- R8: A read of address 6 or 7 returns zero.
- R9: Between dumps the held registers do not change, whatever samples arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_blank | input | 1 | Sample has zero magnitude; it must not be integrated |
| sig_i | input | 1 | In-phase sign (0 = +1, 1 = -1) |
| sig_q | input | 1 | Quadrature sign (0 = +1, 1 = -1) |
| code_prompt | input | 1 | On-time code replica bit |
| code_early | input | 1 | Half-chip early code replica bit |
| code_late | input | 1 | Half-chip late code replica bit |
| dump | input | 1 | End of integration interval: copy the totals, then restart the counters |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Held register index |
| rd_data | output | CNT_W | Held value read back, signed |
| rd_valid | output | 1 | `rd_data` carries the result of the previous read |
| data_ready | output | 1 | A fresh held set is waiting to be read |

## Verification
The assertions check on every cycle that an idle or blanked cycle leaves each counter unchanged and that a counter sitting at a limit stays there when pushed further. They also check that the held registers copy the running value exactly on a dump and stay frozen otherwise, and that the ready flag and the read strobe respond one cycle later. The exact totals need the bench's scenarios. These are the mix of code and sign patterns, the placement of a sample on the dump cycle, and saturation driven from both sides on a narrow copy of the block. The order in which reads clear the ready flag also needs the bench.

// File: rtl/corr_pkg.sv
package corr_pkg;
  // Number of correlation lanes: {I,Q} x {prompt, early, late}
  localparam int NLANE  = 6;
  localparam int NPHASE = 3;
  // Lane index = 2*phase + (quadrature ? 1 : 0); the read address uses the same index
  typedef enum logic [2:0] {
    LN_PROMPT_I = 3'd0,
    LN_PROMPT_Q = 3'd1,
    LN_EARLY_I  = 3'd2,
    LN_EARLY_Q  = 3'd3,
    LN_LATE_I   = 3'd4,
    LN_LATE_Q   = 3'd5
  } lane_e;
endpackage

// File: rtl/corr_product.sv
module corr_product import corr_pkg::*; (
  input  logic              sig_i,
  input  logic              sig_q,
  input  logic [NPHASE-1:0] code,
  output logic [NLANE-1:0]  step_dn
);
  // A sign-bit XOR is the product of two +-1 values; 1 means a negative product
  for (genvar ph = 0; ph < NPHASE; ph++) begin : g_phase
    assign step_dn[2*ph]   = sig_i ^ code[ph];
    assign step_dn[2*ph+1] = sig_q ^ code[ph];
  end
endmodule

// File: rtl/corr_lane.sv
module corr_lane #(
  parameter int CNT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_en,
  input  logic                    step_dn,
  input  logic                    dump,
  output logic signed [CNT_W-1:0] held
);
  localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic signed [CNT_W-1:0] cnt;
  logic signed [CNT_W-1:0] base;
  logic signed [CNT_W-1:0] nxt;

  // On a boundary the new interval starts from zero and may take this cycle's sample
  always_comb begin
    base = dump ? '0 : cnt;
    nxt  = base;
    if (step_en) begin
      if (step_dn) begin
        if (base != CMIN) nxt = base - ONE;
      end else begin
        if (base != CMAX) nxt = base + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      held <= '0;
    end else begin
      cnt <= nxt;
      if (dump) held <= cnt;
    end
  end

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!dump && !step_en) |=> (cnt == $past(cnt)));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (!dump && step_en && !step_dn && cnt == CMAX) |=> (cnt == CMAX));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (!dump && step_en && step_dn && cnt == CMIN) |=> (cnt == CMIN));
  a_r4_latch_on_dump: assert property (@(posedge clk) disable iff (rst)
    dump |=> (held == $past(cnt)));
  a_r9_held_stable: assert property (@(posedge clk) disable iff (rst)
    !dump |=> $stable(held));
endmodule

// File: rtl/corr_readout.sv
module corr_readout import corr_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dump,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic signed [CNT_W-1:0] held [NLANE],
  output logic signed [CNT_W-1:0] rd_data,
  output logic                    rd_valid,
  output logic                    data_ready
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NLANE - 1);

  logic signed [CNT_W-1:0] sel;

  // Addresses with no lane select zero
  always_comb begin
    sel = '0;
    for (int k = 0; k < NLANE; k++) begin
      if (rd_addr == ADDR_W'(k)) sel = held[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      data_ready <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
      if (dump) data_ready <= 1'b1;
      else if (rd_en && rd_addr == LAST) data_ready <= 1'b0;
    end
  end

  a_r7_ready_on_dump: assert property (@(posedge clk) disable iff (rst)
    dump |=> data_ready);
  a_r7_ready_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == LAST && !dump) |=> !data_ready);
  a_r6_read_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/corr_bank.sv
module corr_bank import corr_pkg::*; #(
  parameter int CNT_W = 24,
  localparam int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic                    smp_blank,
  input  logic                    sig_i,
  input  logic                    sig_q,
  input  logic                    code_prompt,
  input  logic                    code_early,
  input  logic                    code_late,
  input  logic                    dump,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic signed [CNT_W-1:0] rd_data,
  output logic                    rd_valid,
  output logic                    data_ready
);
  logic [NPHASE-1:0]       code;
  logic [NLANE-1:0]        step_dn;
  logic                    step_en;
  logic signed [CNT_W-1:0] held [NLANE];

  assign code    = {code_late, code_early, code_prompt};
  assign step_en = smp_valid & ~smp_blank;

  corr_product u_product (
    .sig_i   (sig_i),
    .sig_q   (sig_q),
    .code    (code),
    .step_dn (step_dn)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    corr_lane #(.CNT_W(CNT_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .step_en (step_en),
      .step_dn (step_dn[k]),
      .dump    (dump),
      .held    (held[k])
    );
  end

  corr_readout #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_readout (
    .clk        (clk),
    .rst        (rst),
    .dump       (dump),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .held       (held),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .data_ready (data_ready)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!rd_valid && !data_ready));
endmodule

// File: tb/corr_bank_tb.sv
`timescale 1ns/1ps
module corr_bank_tb_top;
  localparam int NARROW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 0, smp_blank = 0, sig_i = 0, sig_q = 0;
  logic code_p = 0, code_e = 0, code_l = 0, dump = 0, rd_en = 0;
  logic [2:0] rd_addr = '0;
  logic signed [23:0]       rd_w;
  logic signed [NARROW-1:0] rd_n;
  logic vld_w, vld_n, rdy_w, rdy_n;

  always #2.5 clk = ~clk;

  corr_bank dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_blank(smp_blank),
    .sig_i(sig_i), .sig_q(sig_q), .code_prompt(code_p), .code_early(code_e),
    .code_late(code_l), .dump(dump), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_w), .rd_valid(vld_w), .data_ready(rdy_w));

  corr_bank #(.CNT_W(NARROW)) dut_narrow_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_blank(smp_blank),
    .sig_i(sig_i), .sig_q(sig_q), .code_prompt(code_p), .code_early(code_e),
    .code_late(code_l), .dump(dump), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_n), .rd_valid(vld_n), .data_ready(rdy_n));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int run_w [6], run_n [6], hld_w [6], hld_n [6];
  bit rdy_exp = 0;

  // Fields: [6] valid, [5] blank, [4] sig_i, [3] sig_q, [2] prompt, [1] early, [0] late
  localparam logic [6:0] VEC [16] = '{
    7'b1000000, 7'b1010000, 7'b1001000, 7'b1000100,
    7'b1000010, 7'b1000001, 7'b1011111, 7'b1100000,
    7'b0011111, 7'b1010101, 7'b1001010, 7'b1110110,
    7'b1000110, 7'b1011001, 7'b1000000, 7'b1011100
  };

  function automatic int sat(int v, bit dn, int w);
    int hi = (1 << (w - 1)) - 1;
    int lo = -(1 << (w - 1));
    if (dn) return (v == lo) ? v : v - 1;
    return (v == hi) ? v : v + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle of stimulus; the expected totals follow R2-R5 directly
  task automatic put(logic [6:0] v, bit d);
    smp_valid = v[6]; smp_blank = v[5]; sig_i = v[4]; sig_q = v[3];
    code_p = v[2]; code_e = v[1]; code_l = v[0]; dump = d;
    @(posedge clk); #1;
    dump = 0; smp_valid = 0; smp_blank = 0;
    if (d) begin
      for (int k = 0; k < 6; k++) begin
        hld_w[k] = run_w[k]; hld_n[k] = run_n[k]; run_w[k] = 0; run_n[k] = 0;
      end
      rdy_exp = 1;
    end
    if (v[6] && !v[5]) begin
      for (int k = 0; k < 6; k++) begin
        bit dn = ((k % 2) ? v[3] : v[4]) ^ v[2 - k / 2];
        run_w[k] = sat(run_w[k], dn, 24);
        run_n[k] = sat(run_n[k], dn, NARROW);
      end
    end
  endtask

  task automatic rd(int a, string req);
    int ew, en;
    rd_en = 1; rd_addr = 3'(a);
    @(posedge clk); #1;
    rd_en = 0;
    ew = (a < 6) ? hld_w[a] : 0;
    en = (a < 6) ? hld_n[a] : 0;
    if (a == 5) rdy_exp = 0;
    check(int'(rd_w) == ew, req, int'(rd_w), ew);
    check(int'(rd_n) == en, req, int'(rd_n), en);
    check(vld_w == 1'b1, "R6 rd_valid", int'(vld_w), 1);
  endtask

  task automatic rd_all(string req);
    for (int a = 0; a < 6; a++) rd(a, req);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) begin
      run_w[k] = 0; run_n[k] = 0; hld_w[k] = 0; hld_n[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    check(rdy_w == 0 && vld_w == 0, "R1 ready/valid", int'(rdy_w), 0);
    rd_all("R1 held zero");
    put(7'b0, 1'b1);
    rd_all("R1 running zero");
    // R2/R3/R6: table walk, then boundary and read-out
    for (int i = 0; i < 16; i++) put(VEC[i], 1'b0);
    put(7'b0, 1'b1);
    check(rdy_w == 1, "R7 ready after dump", int'(rdy_w), 1);
    for (int a = 0; a < 5; a++) rd(a, "R2 R6 totals");
    check(rdy_w == 1, "R7 ready kept by early reads", int'(rdy_w), 1);
    rd(5, "R2 R6 totals");
    check(rdy_w == 0, "R7 ready cleared by last read", int'(rdy_w), 0);
    // R3: blanked and invalid samples only
    for (int i = 0; i < 8; i++) put(7'b1110101, 1'b0);
    for (int i = 0; i < 8; i++) put(7'b0011010, 1'b0);
    put(7'b0, 1'b1);
    rd_all("R3 blanked ignored");
    // R4: sample on the dump cycle belongs to the new interval
    put(7'b1000000, 1'b0);
    put(7'b1000000, 1'b0);
    put(7'b1011111, 1'b1);
    rd_all("R4 boundary first");
    put(7'b0, 1'b1);
    rd_all("R4 boundary sample kept");
    // R9: held set frozen while new samples arrive
    for (int i = 0; i < 5; i++) put(7'b1001000, 1'b0);
    rd_all("R9 held stable");
    // R5: saturation on the narrow copy, both directions
    for (int i = 0; i < 40; i++) put(7'b1000000, 1'b0);
    put(7'b1011000, 1'b1);
    rd_all("R5 saturate high");
    for (int i = 0; i < 60; i++) put(7'b1011000, 1'b0);
    put(7'b0, 1'b1);
    rd_all("R5 saturate low");
    // R8: unmapped addresses
    rd(6, "R8 addr6");
    rd(7, "R8 addr7");
    // R7: dump and last read in the same cycle
    rd_en = 1; rd_addr = 3'd5;
    put(7'b0, 1'b1);
    rd_en = 0;
    check(rdy_w == 1 && rdy_n == 1, "R7 dump wins", int'(rdy_w), 1);
    check(rdy_w == rdy_exp, "R7 model", int'(rdy_w), int'(rdy_exp));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule